// File: doc/BRIEF.md
# Edge-Selectable 16-Line GPIO Port

This block is a sixteen-line general-purpose I/O port behind a small register interface that takes 16-bit accesses only. Software sets per-line direction, output data, a single edge polarity per line, an interrupt mask and a pin-control gate for input reads. Lines configured as inputs watch for the selected edge. When the line is unmasked, that edge sets a sticky status bit. Any set status bit raises one combined interrupt request. Input lines arrive already synchronised to the register clock.

Register accesses pass through a small access state machine. States: `ACC_IDLE` waits for a request. `ACC_IDLE -> ACC_WRITE` is taken on a valid 16-bit write, `ACC_IDLE -> ACC_READ` on a valid 16-bit read, and `ACC_IDLE -> ACC_REFUSE` on any access of another width. Each of the three active states lasts one cycle and returns to `ACC_IDLE`. A write takes effect at the clock edge that ends `ACC_WRITE`. Read data is presented during `ACC_READ`, together with `acc_done`.

Top module: `gpio16_port`

## Requirements
- R1: Register offsets (byte address): 0x00 data-in (read-only), 0x04 data-out, 0x08 direction, 0x0C edge polarity, 0x10 interrupt mask, 0x14 interrupt status, 0x18 pin control. Any other offset reads as 0, and a write to it changes nothing.
- R2: A direction bit of 1 makes the line an input. `pin_oe` bit is 1 exactly when the direction bit is 0. `pin_out` carries the data-out bit on such lines and 0 on input lines.
- R3: A polarity bit of 1 selects the rising edge of that line, and 0 selects the falling edge. An edge is found by comparing `pin_in` with its copy registered on the previous clock.
- R4: A detected edge sets the line's status bit only when the direction bit is 1 and the mask bit is 0.
- R5: Writing the status register clears each bit written as 1 and keeps the others. If a new edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `irq` is the registered OR of all status bits and follows the status one cycle later.
- R7: Reading data-in returns the registered input levels ANDed with pin control. Writes to data-in are ignored.
- R8: `acc_size` encodes width (0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit). Any code other than 1 is refused: `acc_err` pulses, `acc_done` stays 0, read data is 0, and no register changes.
- R9: After reset, data-out, direction, polarity, mask and pin control are all ones, and status and `irq` are zero.
- R10: A request in `ACC_IDLE` is answered in the next cycle: `acc_done` (with `acc_rdata` for reads) or `acc_err` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access request, sampled in ACC_IDLE |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access width code |
| acc_addr | input | 8 | Byte offset of the register |
| acc_wdata | input | 16 | Write data |
| acc_done | output | 1 | Valid access completes this cycle |
| acc_err | output | 1 | Access refused this cycle |
| acc_rdata | output | 16 | Read data, valid with acc_done on reads |
| pin_in | input | 16 | Synchronised input levels |
| pin_out | output | 16 | Output levels, gated by direction |
| pin_oe | output | 16 | Output enable per line |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sets up a status clear on a line and, in the same cycle, an edge on that line. A design that let the clear win would lose that interrupt. It changes inputs while lines are masked or set as outputs, and checks that no status appears: a design that ignored either gate would raise spurious interrupts. It sends 8-bit and 32-bit accesses to every register and then reads the registers back. A design that did not refuse them would let those accesses corrupt state. Random pin changes under mixed polarity catch a design that swaps rising and falling edges or fires on both edges.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
    localparam logic [7:0] OFS_DIN   = 8'h00;
    localparam logic [7:0] OFS_DOUT  = 8'h04;
    localparam logic [7:0] OFS_DIR   = 8'h08;
    localparam logic [7:0] OFS_POL   = 8'h0C;
    localparam logic [7:0] OFS_MASK  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_PCTL  = 8'h18;

    localparam logic [1:0] SIZE_HALF = 2'd1;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_WRITE  = 2'd1,
        ACC_READ   = 2'd2,
        ACC_REFUSE = 2'd3
    } acc_state_e;
endpackage

// File: rtl/gpio16_access_fsm.sv
module gpio16_access_fsm
    import gpio16_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wdata,
    output logic              wr_stb,
    output logic              rd_act,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LINES-1:0]  cmd_wdata
);
    acc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // command capture, only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr  <= '0;
            cmd_wdata <= '0;
        end else if (state_q == ACC_IDLE && req) begin
            cmd_addr  <= addr;
            cmd_wdata <= wdata;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (req) begin
                    if (size != SIZE_HALF) state_d = ACC_REFUSE;
                    else if (wr)           state_d = ACC_WRITE;
                    else                   state_d = ACC_READ;
                end
            end
            ACC_WRITE:  state_d = ACC_IDLE;
            ACC_READ:   state_d = ACC_IDLE;
            ACC_REFUSE: state_d = ACC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_stb = 1'b0;
        rd_act = 1'b0;
        done   = 1'b0;
        err    = 1'b0;
        unique case (state_q)
            ACC_IDLE:   ;
            ACC_WRITE:  begin wr_stb = 1'b1; done = 1'b1; end
            ACC_READ:   begin rd_act = 1'b1; done = 1'b1; end
            ACC_REFUSE: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio16_regfile.sv
module gpio16_regfile
    import gpio16_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  pins_q,
    input  logic [LINES-1:0]  stat,
    output logic [LINES-1:0]  dout,
    output logic [LINES-1:0]  dir,
    output logic [LINES-1:0]  pol,
    output logic [LINES-1:0]  mask,
    output logic [LINES-1:0]  pctl,
    output logic [LINES-1:0]  clr_vec,
    output logic [LINES-1:0]  rdata
);
    localparam logic [LINES-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= ALL_ONES;
            dir  <= ALL_ONES;
            pol  <= ALL_ONES;
            mask <= ALL_ONES;
            pctl <= ALL_ONES;
        end else if (wr_stb) begin
            case (addr)
                ADDR_W'(OFS_DOUT): dout <= wdata;
                ADDR_W'(OFS_DIR):  dir  <= wdata;
                ADDR_W'(OFS_POL):  pol  <= wdata;
                ADDR_W'(OFS_MASK): mask <= wdata;
                ADDR_W'(OFS_PCTL): pctl <= wdata;
                default: ;
            endcase
        end
    end

    assign clr_vec = (wr_stb && addr == ADDR_W'(OFS_STAT)) ? wdata : '0;

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            case (addr)
                ADDR_W'(OFS_DIN):  rdata = pins_q & pctl;
                ADDR_W'(OFS_DOUT): rdata = dout;
                ADDR_W'(OFS_DIR):  rdata = dir;
                ADDR_W'(OFS_POL):  rdata = pol;
                ADDR_W'(OFS_MASK): rdata = mask;
                ADDR_W'(OFS_STAT): rdata = stat;
                ADDR_W'(OFS_PCTL): rdata = pctl;
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio16_edge_irq.sv
module gpio16_edge_irq #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_in,
    input  logic [LINES-1:0] dir,
    input  logic [LINES-1:0] pol,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] clr_vec,
    output logic [LINES-1:0] pins_q,
    output logic [LINES-1:0] stat,
    output logic             irq
);
    logic [LINES-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pin_in;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic rise, fall;
        assign rise   = pin_in[g] & ~pins_q[g];
        assign fall   = ~pin_in[g] & pins_q[g];
        assign hit[g] = (pol[g] ? rise : fall) & dir[g] & ~mask[g];
    end

    // a new edge outranks a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= (stat & ~clr_vec) | hit;
            irq  <= |stat;
        end
    end
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port #(
    parameter int ADDR_W = 8,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_wr,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LINES-1:0]  acc_wdata,
    output logic              acc_done,
    output logic              acc_err,
    output logic [LINES-1:0]  acc_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq
);
    logic              wr_stb, rd_act;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LINES-1:0]  cmd_wdata;
    logic [LINES-1:0]  dout_w, dir_w, pol_w, mask_w, pctl_w, clr_w;
    logic [LINES-1:0]  pins_q_w, stat_w;

    gpio16_access_fsm #(.ADDR_W(ADDR_W), .LINES(LINES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(acc_req), .wr(acc_wr),
        .size(acc_size), .addr(acc_addr), .wdata(acc_wdata),
        .wr_stb(wr_stb), .rd_act(rd_act), .done(acc_done), .err(acc_err),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
    );

    gpio16_regfile #(.ADDR_W(ADDR_W), .LINES(LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_act(rd_act),
        .addr(cmd_addr), .wdata(cmd_wdata), .pins_q(pins_q_w), .stat(stat_w),
        .dout(dout_w), .dir(dir_w), .pol(pol_w), .mask(mask_w),
        .pctl(pctl_w), .clr_vec(clr_w), .rdata(acc_rdata)
    );

    gpio16_edge_irq #(.LINES(LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir_w),
        .pol(pol_w), .mask(mask_w), .clr_vec(clr_w),
        .pins_q(pins_q_w), .stat(stat_w), .irq(irq)
    );

    assign pin_oe  = ~dir_w;
    assign pin_out = dout_w & ~dir_w;
endmodule

// File: rtl/gpio16_port_checker.sv
module gpio16_port_checker #(
    parameter int LINES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] stat,
    input logic [LINES-1:0] dir,
    input logic [LINES-1:0] mask,
    input logic [LINES-1:0] dout,
    input logic [LINES-1:0] pin_out,
    input logic [LINES-1:0] pin_oe,
    input logic             irq,
    input logic             acc_done,
    input logic             acc_err
);
    // R6: interrupt follows the status one cycle later
    p_irq_lags_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|$past(stat)));

    // R4: a newly set status bit needs an unmasked input the cycle before
    p_set_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat)) & ~($past(dir) & ~$past(mask))) == '0);

    // R2: no output level on a line that is not driven
    p_out_only_when_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R8: a refused access leaves the configuration untouched
    p_refuse_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> ($stable(dir) && $stable(dout) && $stable(mask)));

    // R10: completion and refusal are never signalled together, and last one cycle
    p_resp_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_done, acc_err}));
    p_resp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done || acc_err) |=> !(acc_done || acc_err));
endmodule

bind gpio16_port gpio16_port_checker #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat(stat_w), .dir(dir_w), .mask(mask_w),
    .dout(dout_w), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
    .acc_done(acc_done), .acc_err(acc_err)
);

// File: tb/test_gpio16_port.sv
module test_gpio16_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0, acc_wr = 1'b0;
    logic [1:0]  acc_size = 2'd1;
    logic [7:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        acc_done, acc_err, irq;
    logic [15:0] acc_rdata, pin_out, pin_oe;
    logic [15:0] pin_in = '0;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // model state
    logic [15:0] m_dout, m_dir, m_pol, m_mask, m_stat, m_pctl, m_pin;

    always #10 clk = ~clk; // 50 MHz

    gpio16_port i_gpio16_port (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_err(acc_err), .acc_rdata(acc_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_pin & m_pctl;
            8'h04: return m_dout;
            8'h08: return m_dir;
            8'h0C: return m_pol;
            8'h10: return m_mask;
            8'h14: return m_stat;
            8'h18: return m_pctl;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] edge_hits(input logic [15:0] nv);
        return ((nv & ~m_pin & m_pol) | (~nv & m_pin & ~m_pol)) & m_dir & ~m_mask;
    endfunction

    // one access; optional pin change lands in the same cycle as the register update
    task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [15:0] w, input bit pin_chg, input logic [15:0] pv);
        logic [15:0] hits;
        @(negedge clk);
        acc_req = 1'b1; acc_wr = wr; acc_addr = a; acc_size = sz; acc_wdata = w;
        @(posedge clk);
        @(negedge clk);
        acc_req = 1'b0;
        if (sz != 2'd1) begin
            check("R8 err pulse", {31'd0, acc_err}, 32'd1);
            check("R8 no done", {31'd0, acc_done}, 32'd0);
            check("R8 rdata zero", {16'd0, acc_rdata}, 32'd0);
        end else begin
            check("R10 done pulse", {30'd0, acc_done, acc_err}, 32'd2);
            if (!wr) check("R1 read data", {16'd0, acc_rdata}, {16'd0, exp_read(a)});
        end
        hits = 16'h0;
        if (pin_chg) begin
            hits = edge_hits(pv);
            pin_in = pv;
        end
        if (wr && sz == 2'd1) begin
            case (a)
                8'h04: m_dout = w;
                8'h08: m_dir  = w;
                8'h0C: m_pol  = w;
                8'h10: m_mask = w;
                8'h14: m_stat = m_stat & ~w;
                8'h18: m_pctl = w;
                default: ;
            endcase
        end
        m_stat = m_stat | hits;
        if (pin_chg) m_pin = pv;
        @(posedge clk);
        @(negedge clk);
        check("R10 idle after access", {30'd0, acc_done, acc_err}, 32'd0);
    endtask

    task automatic set_pins(input logic [15:0] pv);
        @(negedge clk);
        m_stat = m_stat | edge_hits(pv);
        pin_in = pv;
        m_pin  = pv;
        @(posedge clk);
    endtask

    task automatic check_outputs(input string tag);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 oe"},  {16'd0, pin_oe},  {16'd0, ~m_dir});
        check({tag, " R2 out"}, {16'd0, pin_out}, {16'd0, m_dout & ~m_dir});
        check({tag, " R6 irq"}, {31'd0, irq},     {31'd0, (m_stat != 16'h0)});
    endtask

    task automatic read_chk(input logic [7:0] a);
        access(1'b0, a, 2'd1, 16'h0, 1'b0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5086));
        m_dout = 16'hFFFF; m_dir = 16'hFFFF; m_pol = 16'hFFFF; m_mask = 16'hFFFF;
        m_pctl = 16'hFFFF; m_stat = 16'h0; m_pin = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check("R9 irq", {31'd0, irq}, 32'd0);
        check("R9 oe", {16'd0, pin_oe}, 32'd0);
        for (int k = 0; k < 8; k++) read_chk(8'(k * 4));

        // R7: data-in gated by pin control, writes ignored
        set_pins(16'hA5C3);
        access(1'b1, 8'h18, 2'd1, 16'h0FF0, 1'b0, 16'h0);
        read_chk(8'h00);
        access(1'b1, 8'h00, 2'd1, 16'h1234, 1'b0, 16'h0);
        read_chk(8'h00); // R7 write to data-in left no trace
        access(1'b1, 8'h20, 2'd1, 16'h5555, 1'b0, 16'h0); // R1 unused offset
        for (int k = 0; k < 9; k++) read_chk(8'(k * 4));

        // R2: outputs on low half only
        access(1'b1, 8'h08, 2'd1, 16'hFF00, 1'b0, 16'h0);
        access(1'b1, 8'h04, 2'd1, 16'h3C5A, 1'b0, 16'h0);
        check_outputs("dir");

        // R4: masked inputs and output lines raise nothing
        set_pins(16'h0000);
        set_pins(16'hFFFF);
        check_outputs("R4 masked");
        check("R4 status clear", {16'd0, m_stat}, 32'd0);

        // R3: rising on line 8, falling on line 9
        access(1'b1, 8'h0C, 2'd1, 16'hFDFF, 1'b0, 16'h0);
        access(1'b1, 8'h10, 2'd1, 16'hFCFF, 1'b0, 16'h0);
        set_pins(16'hFCFF); // line 8 and 9 fall: only 9 sets
        check_outputs("R3 fall");
        read_chk(8'h14);
        set_pins(16'hFFFF); // both rise: only 8 sets
        check_outputs("R3 rise");
        read_chk(8'h14);

        // R5: write-one-to-clear of bit 9 only
        access(1'b1, 8'h14, 2'd1, 16'h0200, 1'b0, 16'h0);
        read_chk(8'h14);
        // R5: edge on line 8 in the same cycle as its clear: edge wins
        set_pins(16'hFEFF);
        access(1'b1, 8'h14, 2'd1, 16'h0100, 1'b1, 16'hFFFF);
        read_chk(8'h14);
        check("R5 edge wins", {16'd0, m_stat}, 32'h0100);
        access(1'b1, 8'h14, 2'd1, 16'hFFFF, 1'b0, 16'h0);
        check_outputs("R6 drop");

        // R8: refused widths against every register
        for (int k = 0; k < 7; k++) begin
            access(1'b1, 8'(k * 4), 2'd0, 16'h0000, 1'b0, 16'h0);
            access(1'b1, 8'(k * 4), 2'd2, 16'h0000, 1'b0, 16'h0);
        end
        access(1'b0, 8'h04, 2'd3, 16'h0, 1'b0, 16'h0);
        for (int k = 0; k < 7; k++) read_chk(8'(k * 4));

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int unsigned op = $urandom_range(0, 9);
            logic [7:0] a = 8'($urandom_range(0, 8) * 4);
            logic [15:0] w = 16'($urandom);
            if (op < 3)       access(1'b1, a, 2'd1, w, 1'b0, 16'h0);
            else if (op < 6)  read_chk(a);
            else if (op < 8)  set_pins(16'($urandom));
            else if (op == 8) access(1'b1, 8'h14, 2'd1, w, 1'b1, 16'($urandom));
            else              access(1'($urandom), a, 2'd2, w, 1'b0, 16'h0);
            if (n % 16 == 0) check_outputs("rnd");
        end
        check_outputs("final");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule